// File: doc/BRIEF.md
# DMA External Request Handshake

This block serves the external-request side of a single DMA channel. An active-low request line from outside the chip is brought into the clock domain by a synchronizer. It is then qualified either as a low level or as a falling edge, and held in a pending flag until the channel can start a transfer. Each start is reported to the bus engine as a one-cycle pulse. While that transfer runs, the block drives an active-low acknowledge and an active-low end-of-block output, each gated by its own enable.

Software arms the channel by writing an enable bit and a transfer count. The bus engine pulses a done strobe when each transfer completes, and the block counts the transfers down. After the final one, the block drops its own enable and the channel returns to the disabled state. A mode bit can hold off new requests for one extra cycle after each completion. A status word carries a single read-only active flag.

Top module: `xreq_handshake`

## Requirements
- R1: After reset, `ack_n` and `end_n` are 1, `start_o` is 0 and `sts` is all zero.
- R2: With level detection and the channel waiting, `start_o` pulses on the fourth rising edge after `req_n` goes low: SYNC_STAGES flops, one edge to latch the request, and one edge to start.
- R3: With edge detection (`mode_edge`=1), the first request after a control write is accepted on a low level. Each later request needs a falling edge of `req_n`, so a line held low after the first transfer starts nothing more. A falling edge that arrives during a transfer is kept for the next one.
- R4: `mode_slow`=0 lets the channel accept the next request in the cycle after the done strobe. `mode_slow`=1 lets it accept one cycle later. With `req_n` held low in level mode, the next `start_o` comes 2 edges (slow: 3) after the done edge. A falling edge latched during the transfer in edge mode gives 1 edge (slow: 2).
- R5: In level mode, a low `req_n` seen during a transfer is not latched. It is re-evaluated only once the channel waits again.
- R6: `ack_n` is 0 only during a transfer, and only if `ack_oe`=1 and `mode_single`=1. With `mode_single`=0, `ack_n` stays 1 whatever the value of `ack_oe`.
- R7: `end_n` is 0 only during the transfer whose done strobe takes the remaining count from 1 to 0, and only if `end_oe`=1.
- R8: `sts[0]` is 1 while a transfer runs or during the delay cycle that follows it. It is 0 while the channel waits or is disabled. Bits `sts[STS_W-1:1]` always read 0.
- R9: After the done strobe of the last counted transfer, the channel disables itself. `sts[0]` is then 0 and no `start_o` follows, even with `req_n` low. A control write with enable 1 and a count of 0 also leaves the channel disabled.
- R10: A control write with `ctl_en`=0 disables the channel on that edge. `sts[0]` and the acknowledge go inactive and no later start occurs.
- R11: `start_o` is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe: loads enable and count |
| ctl_en | input | 1 | Channel enable value for the control write |
| ctl_count | input | CNT_W | Number of transfers for the control write |
| mode_single | input | 1 | 1 = single address mode, 0 = dual address mode |
| mode_edge | input | 1 | 1 = falling-edge detection, 0 = low-level detection |
| mode_slow | input | 1 | 1 = accept next request one cycle after completion |
| ack_oe | input | 1 | Acknowledge output enable |
| end_oe | input | 1 | End-of-block output enable |
| req_n | input | 1 | Asynchronous active-low transfer request |
| xfer_done | input | 1 | Strobe from the bus engine: current transfer completed |
| start_o | output | 1 | One-cycle pulse: a transfer begins |
| ack_n | output | 1 | Active-low acknowledge |
| end_n | output | 1 | Active-low end-of-block indication |
| sts | output | STS_W | Status word: bit 0 active, other bits read 0 |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, the edge-capable detector variant, an 8-bit count and an 8-bit status word. The short synchronizer makes the request-to-start latency an exact four edges, which the bench can check cycle by cycle. With the edge variant present, both detection modes and the level-taken first request can be exercised in one build. Counts of 1 to 3 reach the final transfer, and with it the end-of-block output and the self-disable, in a few cycles.

// File: rtl/xreq_pkg.sv
package xreq_pkg;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_WAIT = 2'd1,
      ST_BUSY = 2'd2,
      ST_GAP  = 2'd3
   } xreq_state_e;

   function automatic logic is_active(input xreq_state_e s);
      return (s == ST_BUSY) || (s == ST_GAP);
   endfunction

endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xreq_detect.sv
module xreq_detect #(
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,      // synchronized, active low
   input  logic mode_edge,
   input  logic first,      // no transfer started since last control write
   input  logic window,     // channel waiting, acceptance open
   input  logic armed,      // channel enabled
   input  logic take,       // pending request consumed this cycle
   input  logic clr,
   output logic pend
);
   logic prev_q, pend_q;
   logic lvl_hit, edge_sel, fall_hit, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= req_s;
   end

   assign lvl_hit = !req_s && window;

   generate
      if (HAS_EDGE) begin : g_edge
         assign edge_sel = mode_edge && !first;
         assign fall_hit = prev_q && !req_s && armed;
      end else begin : g_level
         assign edge_sel = 1'b0;
         assign fall_hit = 1'b0;
      end
   endgenerate

   assign hit = edge_sel ? fall_hit : lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (clr)   pend_q <= 1'b0;
      else if (take)  pend_q <= edge_sel && fall_hit;
      else if (hit)   pend_q <= 1'b1;
   end

   assign pend = pend_q;
endmodule

// File: rtl/xreq_count.sv
module xreq_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - ONE;
   end

   assign last = (cnt_q == ONE);
endmodule

// File: rtl/xreq_handshake.sv
module xreq_handshake
   import xreq_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int STS_W       = 8,
   parameter bit HAS_EDGE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_en,
   input  logic [CNT_W-1:0] ctl_count,
   input  logic             mode_single,
   input  logic             mode_edge,
   input  logic             mode_slow,
   input  logic             ack_oe,
   input  logic             end_oe,
   input  logic             req_n,
   input  logic             xfer_done,
   output logic             start_o,
   output logic             ack_n,
   output logic             end_n,
   output logic [STS_W-1:0] sts
);
   localparam int RSV_W = STS_W - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (STS_W < 1) begin : g_bad_sts
         $error("STS_W must be at least 1");
      end
   endgenerate

   xreq_state_e state_q;
   logic req_s, pend, first_q, start_q, last;
   logic window, armed, take, busy, finish, arm_ok;

   xreq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_s));

   assign window = (state_q == ST_WAIT);
   assign armed  = (state_q != ST_OFF);
   assign busy   = (state_q == ST_BUSY);
   assign take   = window && pend && !ctl_wr;
   assign finish = busy && xfer_done && !ctl_wr;
   assign arm_ok = ctl_en && (ctl_count != '0);

   xreq_detect #(.HAS_EDGE(HAS_EDGE)) u_det (
      .clk(clk), .rst_n(rst_n), .req_s(req_s), .mode_edge(mode_edge),
      .first(first_q), .window(window), .armed(armed), .take(take),
      .clr(ctl_wr), .pend(pend));

   xreq_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(ctl_wr), .load_val(ctl_count),
      .dec(finish), .last(last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         first_q <= 1'b1;
         start_q <= 1'b0;
      end else begin
         start_q <= take;
         if (ctl_wr) begin
            state_q <= arm_ok ? ST_WAIT : ST_OFF;
            first_q <= 1'b1;
         end else begin
            if (take) first_q <= 1'b0;
            unique case (state_q)
               ST_OFF:  state_q <= ST_OFF;
               ST_WAIT: if (pend) state_q <= ST_BUSY;
               ST_BUSY: if (xfer_done)
                           state_q <= last ? ST_OFF : (mode_slow ? ST_GAP : ST_WAIT);
               ST_GAP:  state_q <= ST_WAIT;
               default: state_q <= ST_OFF;
            endcase
         end
      end
   end

   assign start_o = start_q;
   assign ack_n   = !(busy && ack_oe && mode_single);
   assign end_n   = !(busy && end_oe && last);

   generate
      if (STS_W > 1) begin : g_sts_wide
         assign sts = {{RSV_W{1'b0}}, is_active(state_q)};
      end else begin : g_sts_bit
         assign sts = is_active(state_q);
      end
   endgenerate
endmodule

// File: rtl/xreq_handshake_chk.sv
module xreq_handshake_chk #(
   parameter int STS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic             ctl_en,
   input logic             mode_single,
   input logic             xfer_done,
   input logic             start_o,
   input logic             ack_n,
   input logic             end_n,
   input logic [STS_W-1:0] sts
);
   a_r6_no_ack_dual: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_single |-> ack_n);

   a_r8_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sts >> 1) == '0);

   a_r8_start_active: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> sts[0]);

   a_r7_end_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      !end_n |-> sts[0]);

   a_r6_ack_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> sts[0]);

   a_r9_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (!end_n && xfer_done && !ctl_wr) |=> (!sts[0] && !start_o));

   a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_en) |=> (!sts[0] && !start_o && ack_n));

   a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);
endmodule

bind xreq_handshake xreq_handshake_chk #(.STS_W(STS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
   .mode_single(mode_single), .xfer_done(xfer_done), .start_o(start_o),
   .ack_n(ack_n), .end_n(end_n), .sts(sts));

// File: tb/xreq_handshake_bench.sv
module xreq_handshake_bench;
   localparam int CNT_W = 8;
   localparam int STS_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 0, ctl_en = 0, mode_single = 0, mode_edge = 0, mode_slow = 0;
   logic ack_oe = 0, end_oe = 0, req_n = 1, xfer_done = 0;
   logic [CNT_W-1:0] ctl_count = '0;
   logic start_o, ack_n, end_n;
   logic [STS_W-1:0] sts;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   xreq_handshake u_xreq_handshake (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
      .ctl_count(ctl_count), .mode_single(mode_single), .mode_edge(mode_edge),
      .mode_slow(mode_slow), .ack_oe(ack_oe), .end_oe(end_oe), .req_n(req_n),
      .xfer_done(xfer_done), .start_o(start_o), .ack_n(ack_n), .end_n(end_n),
      .sts(sts));

   // fields: edge, slow, single, ack_oe, end_oe, count[7:0]
   localparam logic [12:0] VEC [6] = '{
      {5'b00111, 8'd3},
      {5'b01111, 8'd2},
      {5'b10111, 8'd3},
      {5'b11011, 8'd2},
      {5'b00100, 8'd2},
      {5'b10110, 8'd1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
         cycles++;
      end
   endtask

   task automatic wait_start(output int n);
      n = 0;
      do begin
         tick();
         n++;
      end while (!start_o && n < 20);
   endtask

   task automatic count_starts(input int len, output int n);
      n = 0;
      for (int k = 0; k < len; k++) begin
         tick();
         if (start_o) n++;
      end
   endtask

   task automatic ctl_write(input logic en, input logic [CNT_W-1:0] cnt);
      ctl_wr = 1; ctl_en = en; ctl_count = cnt;
      tick();
      ctl_wr = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            finish_run();
         end
      end
   end

   initial begin
      int n;
      int nst;
      // R1: reset state
      tick(3);
      rst_n = 1;
      tick();
      check(ack_n == 1 && end_n == 1, "R1 outputs idle", {ack_n, end_n}, 3);
      check(sts == 0 && start_o == 0, "R1 status zero", int'(sts), 0);

      // table walk
      for (int v = 0; v < 6; v++) begin
         logic e, s, sg, ao, eo;
         int cnt;
         {e, s, sg, ao, eo} = VEC[v][12:8];
         cnt = int'(VEC[v][7:0]);
         mode_edge = e; mode_slow = s; mode_single = sg; ack_oe = ao; end_oe = eo;
         req_n = 0;
         tick(3);
         ctl_write(1'b1, CNT_W'(cnt));
         wait_start(n);
         check(n == 2, e ? "R3 first request taken on level" : "R2 start after enable", n, 2);
         tick();
         check(start_o == 0, "R11 single-cycle start", start_o, 0);
         for (int i = 0; i < cnt; i++) begin
            check(ack_n == !(ao && sg), "R6 acknowledge gating", ack_n, !(ao && sg));
            check(end_n == !(eo && i == cnt - 1), "R7 end-of-block timing", end_n,
                  !(eo && i == cnt - 1));
            check(sts == 1, "R8 active during transfer", int'(sts), 1);
            if (e && i < cnt - 1) begin
               req_n = 1; tick(3);
               req_n = 0; tick(3);
            end
            xfer_done = 1;
            tick();
            xfer_done = 0;
            if (i < cnt - 1) begin
               int exp;
               wait_start(n);
               exp = e ? (s ? 2 : 1) : (s ? 3 : 2);
               check(n == exp, e ? "R4 gap after latched edge" : "R4 R5 gap with level held",
                     n, exp);
            end
         end
         check(sts == 0 && ack_n == 1 && end_n == 1, "R9 idle after last", int'(sts), 0);
         count_starts(10, nst);
         check(nst == 0, "R9 no start after count done", nst, 0);
         req_n = 1;
         tick(3);
      end

      // R3: edge mode, line held low after first transfer
      mode_edge = 1; mode_slow = 0; mode_single = 1; ack_oe = 1; end_oe = 1;
      req_n = 0; tick(3);
      ctl_write(1'b1, CNT_W'(2));
      wait_start(n);
      check(n == 2, "R3 first edge-mode request", n, 2);
      xfer_done = 1; tick(); xfer_done = 0;
      count_starts(10, nst);
      check(nst == 0, "R3 held low gives no new start", nst, 0);
      check(sts == 0, "R8 zero while waiting", int'(sts), 0);
      req_n = 1; tick(3);
      req_n = 0;
      wait_start(n);
      check(n == 4, "R3 falling edge accepted", n, 4);
      xfer_done = 1; tick(); xfer_done = 0;
      req_n = 1; tick(3);

      // R2: level latency from request, then R10 disable mid transfer
      mode_edge = 0;
      ctl_write(1'b1, CNT_W'(3));
      tick(3);
      check(sts == 0 && start_o == 0, "R8 waiting shows inactive", int'(sts), 0);
      req_n = 0;
      wait_start(n);
      check(n == 4, "R2 request to start latency", n, 4);
      check(ack_n == 0, "R6 acknowledge low in single mode", ack_n, 0);
      ctl_write(1'b0, CNT_W'(3));
      check(sts == 0 && ack_n == 1, "R10 disable drops active", int'(sts), 0);
      count_starts(10, nst);
      check(nst == 0, "R10 no start after disable", nst, 0);

      // R9: zero count leaves channel off
      ctl_write(1'b1, CNT_W'(0));
      count_starts(10, nst);
      check(nst == 0 && sts == 0, "R9 zero count stays disabled", nst, 0);

      finish_run();
   end
endmodule